// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a free-running nanosecond count for precision time protocol support. On every reference clock cycle while it is enabled, it adds a programmable nominal step to a count register. A correction phase counter can make the block add a second, separate step instead of the nominal one on one cycle out of a programmable number. This lets software trim the effective rate up or down without changing the reference clock.

The count can fold back at a programmable event period. With a period of 0x80000000, for example, it behaves as a 31-bit counter. A fold can raise a one-cycle pulse for downstream compare channels. Software uses a small register write/read port for three things. It can restart the count. It can load the count directly. It can freeze a snapshot of the count that it reads back later at leisure. The live count is also driven out for neighbouring logic.

Top module: `ptp_ns_timer`

## Requirements
- R1: After reset, `count_o`, `wrap_o`, `slave_o` and `rd_data` are zero, and every register reads as zero.
- R2: While control bit 0 (enable) is set, each clock edge adds the nominal step to the count. The nominal step is held in bits [6:0] of the step register at address 4.
- R3: The rate trim register at address 3 holds a value P. When P is nonzero, the correction step replaces the nominal step on every (P+1)-th enabled cycle, counted from the last restart. The correction step is held in bits [14:8] of the step register. When P is zero, the correction step is never used.
- R4: Folding is active when control bits [5:4] are nonzero and the event period E at address 2 is nonzero. While it is active, a sum that reaches or passes E makes the count become the sum minus E.
- R5: When folding is inactive, the count wraps modulo 2^CNT_W.
- R6: `wrap_o` is high for exactly the cycle that follows an edge at which an R4 fold happened, and only when control bit 7 is set.
- R7: Writing control with bit 9 (restart) set zeroes the count and the correction phase at the edge that accepts the write. Bit 9 reads back as zero.
- R8: Writing control with bit 11 (capture) set latches the count held just before that edge into the snapshot. Reads of address 1 return the snapshot, not the live count. Bit 11 reads back as zero.
- R9: Writing address 1 loads the count with the written value at that edge. This works whether or not the block is enabled.
- R10: While enable is clear, the count and the correction phase hold their values.
- R11: `rd_data` updates on the edge after `rd_en`, from the address in `rd_addr`. Control reads return only bits 0, 4, 5, 7 and 13. Unmapped addresses read zero. Control bit 13 drives `slave_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| count_o | output | 32 | Live nanosecond count |
| wrap_o | output | 1 | One-cycle fold pulse for compare channels |
| slave_o | output | 1 | Slave mode control bit |

## Verification
Every effect of a register write lands at the edge that accepts the write. The bench therefore drives a write half a cycle before an edge and expects restart, load and capture to be visible at the very next falling-edge sample. An increment is due one edge after enable is seen, so the bench compares the count against a closed-form sum at each falling edge after that. The fold pulse appears in the same cycle as the folded count and is checked alongside it. Read data arrives one edge after the strobe, and the bench samples it at the following falling edge.

// File: rtl/ptp_ns_timer_pkg.sv
package ptp_ns_timer_pkg;
  localparam int ADDR_W = 3;

  // register selections
  localparam logic [ADDR_W-1:0] REG_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] REG_TIME    = 3'd1;
  localparam logic [ADDR_W-1:0] REG_EVPER   = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CORRPER = 3'd3;
  localparam logic [ADDR_W-1:0] REG_STEP    = 3'd4;

  // control bit positions
  localparam int CB_EN       = 0;
  localparam int CB_FOLD_LO  = 4;
  localparam int CB_FOLD_HI  = 5;
  localparam int CB_WRAPCMP  = 7;
  localparam int CB_RESTART  = 9;
  localparam int CB_CAPTURE  = 11;
  localparam int CB_SLAVE    = 13;

  // correction step field base in the step register
  localparam int STEP_CORR_LSB = 8;

  typedef struct packed {
    logic       slave;
    logic       wrap_cmp;
    logic [1:0] fold;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/ptp_ns_regs.sv
module ptp_ns_regs
  import ptp_ns_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int CORR_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  snap_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  evper_o,
  output logic [CORR_W-1:0] corrper_o,
  output logic [STEP_W-1:0] step_nom_o,
  output logic [STEP_W-1:0] step_corr_o,
  output logic              restart_o,
  output logic              capture_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  evper_q;
  logic [CORR_W-1:0] corrper_q;
  logic [STEP_W-1:0] nom_q, corr_q;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              wr_ctrl;

  assign wr_ctrl    = wr_en && (wr_addr == REG_CTRL);
  assign restart_o  = wr_ctrl && wr_data[CB_RESTART];
  assign capture_o  = wr_ctrl && wr_data[CB_CAPTURE];
  assign load_o     = wr_en && (wr_addr == REG_TIME);
  assign load_val_o = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      evper_q   <= '0;
      corrper_q <= '0;
      nom_q     <= '0;
      corr_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL: begin
          ctrl_q.en       <= wr_data[CB_EN];
          ctrl_q.fold     <= wr_data[CB_FOLD_HI:CB_FOLD_LO];
          ctrl_q.wrap_cmp <= wr_data[CB_WRAPCMP];
          ctrl_q.slave    <= wr_data[CB_SLAVE];
        end
        REG_EVPER:   evper_q   <= wr_data[CNT_W-1:0];
        REG_CORRPER: corrper_q <= wr_data[CORR_W-1:0];
        REG_STEP: begin
          nom_q  <= wr_data[STEP_W-1:0];
          corr_q <= wr_data[STEP_CORR_LSB +: STEP_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    case (rd_addr)
      REG_CTRL: begin
        rd_d[CB_EN]                 = ctrl_q.en;
        rd_d[CB_FOLD_HI:CB_FOLD_LO] = ctrl_q.fold;
        rd_d[CB_WRAPCMP]            = ctrl_q.wrap_cmp;
        rd_d[CB_SLAVE]              = ctrl_q.slave;
      end
      REG_TIME:    rd_d[CNT_W-1:0]  = snap_i;
      REG_EVPER:   rd_d[CNT_W-1:0]  = evper_q;
      REG_CORRPER: rd_d[CORR_W-1:0] = corrper_q;
      REG_STEP: begin
        rd_d[STEP_W-1:0]              = nom_q;
        rd_d[STEP_CORR_LSB +: STEP_W] = corr_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data     = rd_q;
  assign ctrl_o      = ctrl_q;
  assign evper_o     = evper_q;
  assign corrper_o   = corrper_q;
  assign step_nom_o  = nom_q;
  assign step_corr_o = corr_q;

  // R11
  ctrl_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == REG_CTRL) |=> (rd_data[CB_RESTART] == 1'b0 && rd_data[CB_CAPTURE] == 1'b0));
endmodule

// File: rtl/ptp_ns_rate.sv
module ptp_ns_rate #(
  parameter int STEP_W = 7,
  parameter int CORR_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [CORR_W-1:0] corrper_i,
  input  logic [STEP_W-1:0] step_nom_i,
  input  logic [STEP_W-1:0] step_corr_i,
  output logic [STEP_W-1:0] step_o
);
  logic [CORR_W-1:0] phase_q;
  logic              trim_on, use_corr;

  assign trim_on  = (corrper_i != '0);
  assign use_corr = trim_on && (phase_q >= corrper_i);
  assign step_o   = use_corr ? step_corr_i : step_nom_i;

  always_ff @(posedge clk) begin
    if (rst || restart_i)   phase_q <= '0;
    else if (en_i) begin
      if (use_corr)         phase_q <= '0;
      else if (trim_on)     phase_q <= phase_q + 1'b1;
    end
  end

  // R3
  corr_once_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && use_corr) |=> (phase_q == '0));
  // R10
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !restart_i) |=> $stable(phase_q));
endmodule

// File: rtl/ptp_ns_count.sv
module ptp_ns_count #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              capture_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              fold_en_i,
  input  logic              pulse_en_i,
  input  logic [CNT_W-1:0]  evper_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              wrap_o,
  output logic [CNT_W-1:0]  snap_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] count_q, snap_q, next_cnt;
  logic [SUM_W-1:0] sum, diff;
  logic             fold_hit, wrap_q;

  assign sum      = {1'b0, count_q} + SUM_W'(step_i);
  assign diff     = sum - {1'b0, evper_i};
  assign fold_hit = fold_en_i && (evper_i != '0) && (sum >= {1'b0, evper_i});
  assign next_cnt = fold_hit ? diff[CNT_W-1:0] : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else if (load_i) begin
      count_q <= load_val_i;
      wrap_q  <= 1'b0;
    end else if (en_i) begin
      count_q <= next_cnt;
      wrap_q  <= fold_hit && pulse_en_i;
    end else begin
      wrap_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            snap_q <= '0;
    else if (capture_i) snap_q <= count_q;
  end

  assign count_o = count_q;
  assign wrap_o  = wrap_q;
  assign snap_o  = snap_q;

  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !restart_i && !load_i) |=> $stable(count_q));
  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (count_q == '0));
  // R9
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !restart_i) |=> (count_q == $past(load_val_i)));
  // R8
  capture_value_chk: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> (snap_q == $past(count_q)));
  // R6
  wrap_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> ($past(pulse_en_i) && $past(en_i)));
endmodule

// File: rtl/ptp_ns_timer.sv
module ptp_ns_timer
  import ptp_ns_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int CORR_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              wrap_o,
  output logic              slave_o
);
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  evper, load_val, snap;
  logic [CORR_W-1:0] corrper;
  logic [STEP_W-1:0] step_nom, step_corr, step;
  logic              restart, capture, load;

  initial begin
    if (CNT_W > DATA_W || CORR_W > DATA_W || STEP_W > STEP_CORR_LSB)
      $error("ptp_ns_timer: parameter set out of range");
  end

  ptp_ns_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STEP_W(STEP_W), .CORR_W(CORR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .snap_i(snap), .ctrl_o(ctrl), .evper_o(evper), .corrper_o(corrper),
    .step_nom_o(step_nom), .step_corr_o(step_corr),
    .restart_o(restart), .capture_o(capture), .load_o(load), .load_val_o(load_val)
  );

  ptp_ns_rate #(.STEP_W(STEP_W), .CORR_W(CORR_W)) u_rate (
    .clk(clk), .rst(rst), .en_i(ctrl.en), .restart_i(restart),
    .corrper_i(corrper), .step_nom_i(step_nom), .step_corr_i(step_corr),
    .step_o(step)
  );

  ptp_ns_count #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_count (
    .clk(clk), .rst(rst), .en_i(ctrl.en), .restart_i(restart),
    .load_i(load), .load_val_i(load_val), .capture_i(capture),
    .step_i(step), .fold_en_i(ctrl.fold != 2'b00), .pulse_en_i(ctrl.wrap_cmp),
    .evper_i(evper), .count_o(count_o), .wrap_o(wrap_o), .snap_o(snap)
  );

  assign slave_o = ctrl.slave;
endmodule

// File: tb/ptp_ns_timer_bench.sv
module ptp_ns_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data, count_o;
  logic        wrap_o, slave_o;
  int checks = 0, errors = 0;
  int cycles = 0;

  ptp_ns_timer u_ptp_ns_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .count_o(count_o), .wrap_o(wrap_o), .slave_o(slave_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d, x, exp;
    logic        ew;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 wrap", {31'd0, wrap_o}, 0);
    chk("R1 slave", {31'd0, slave_o}, 0);
    chk("R1 rd_data", rd_data, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 register", d, 0);
    end

    // R2 and R3: sweep nominal, correction and trim period
    foreach (int_arr_dummy[i]) ;
    for (int ni = 0; ni < 3; ni++) begin
      for (int ci = 0; ci < 3; ci++) begin
        for (int pi = 0; pi < 4; pi++) begin
          int n, c, p;
          n = (ni == 0) ? 1 : (ni == 1) ? 3 : 8;
          c = (ci == 0) ? 0 : (ci == 1) ? 5 : 127;
          p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 2 : 4;
          wr(3'd4, (32'(c) << 8) | 32'(n));
          wr(3'd3, 32'(p));
          wr(3'd0, 32'h201);
          chk("R7 restart zero", count_o, 0);
          for (int k = 1; k <= 11; k++) begin
            int m;
            @(negedge clk);
            m = (p == 0) ? 0 : k / (p + 1);
            exp = 32'(k * n + m * (c - n));
            chk(p == 0 ? "R2 nominal step" : "R3 correction step", count_o, exp);
          end
        end
      end
    end

    // R4 and R6: fold at event period 20, step 3, pulse enabled
    wr(3'd4, 32'h0003);
    wr(3'd3, 0);
    wr(3'd2, 20);
    wr(3'd0, 32'h2B1);
    exp = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      exp = exp + 3;
      ew = (exp >= 20);
      if (ew) exp = exp - 20;
      chk("R4 fold count", count_o, exp);
      chk("R6 fold pulse", {31'd0, wrap_o}, {31'd0, ew});
    end
    // R6: pulse gated off by bit 7
    wr(3'd0, 32'h231);
    exp = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      exp = exp + 3;
      if (exp >= 20) exp = exp - 20;
      chk("R4 fold count no pulse", count_o, exp);
      chk("R6 pulse gated", {31'd0, wrap_o}, 0);
    end

    // R9, R10, R5: load while disabled, hold, natural overflow
    wr(3'd4, 32'h0005);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hFFFF_FFFE);
    chk("R9 load while disabled", count_o, 32'hFFFF_FFFE);
    repeat (4) @(negedge clk);
    chk("R10 hold while disabled", count_o, 32'hFFFF_FFFE);
    wr(3'd0, 32'h1);
    chk("R10 enable edge", count_o, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R5 modulo wrap", count_o, 32'h3);
    // R5: fold bits set but event period zero
    wr(3'd0, 32'h0);
    wr(3'd2, 0);
    wr(3'd1, 32'hFFFF_FFFD);
    wr(3'd0, 32'hB1);
    @(negedge clk);
    chk("R5 zero period", count_o, 32'h2);
    chk("R6 no pulse on natural wrap", {31'd0, wrap_o}, 0);
    // R4: 31-bit counter via period 0x80000000
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h8000_0000);
    wr(3'd1, 32'h7FFF_FFFE);
    wr(3'd0, 32'hB1);
    @(negedge clk);
    chk("R4 31-bit fold", count_o, 32'h3);
    chk("R6 31-bit pulse", {31'd0, wrap_o}, 1);

    // R8: capture while running
    wr(3'd2, 0);
    wr(3'd4, 32'h0001);
    wr(3'd0, 32'h201);
    repeat (5) @(negedge clk);
    x = count_o;
    wr_en = 1; wr_addr = 3'd0; wr_data = 32'h801;
    @(negedge clk); wr_en = 0;
    repeat (6) @(negedge clk);
    rd(3'd1, d);
    chk("R8 snapshot value", d, x);
    chk("R8 live moves on", count_o, x + 9);
    rd(3'd0, d);
    chk("R8 R7 self clear", d, 32'h1);

    // R11: register map readback
    wr(3'd4, 32'hFFFF);
    rd(3'd4, d);
    chk("R11 step fields", d, 32'h7F7F);
    wr(3'd3, 32'h5);
    rd(3'd3, d);
    chk("R11 trim period", d, 32'h5);
    wr(3'd2, 32'h1234_5678);
    rd(3'd2, d);
    chk("R11 event period", d, 32'h1234_5678);
    wr(3'd0, 32'hFFFF_FFFF);
    chk("R7 restart via full write", count_o, 0);
    rd(3'd0, d);
    chk("R11 control bits", d, 32'h20B1);
    chk("R11 slave out", {31'd0, slave_o}, 1);
    rd(3'd7, d);
    chk("R11 unmapped", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int int_arr_dummy[1];
endmodule